// File: doc/BRIEF.md
# Trigger Timestamp and Timer Event Unit

This block sits beside a free-running time-of-day counter and turns asynchronous trigger pins, alarm matches and pulse-channel ticks into one set of event flags. Each trigger pin passes through a synchronizer. An edge of the selected polarity stores the counter value that was current when the pin level was first sampled. Each alarm holds a 64-bit compare value. The alarm fires once when the counter crosses that value, and software re-arms it for periodic use. Every event source sets a sticky flag in a shared event word. A mask word with the same bit layout selects which flags raise the interrupt line.

Software accesses the block through a word-wide register port. The read data is combinational from the address. Writes and read strobes act on the rising clock edge.

Top module: `tstamp_event_unit`

## Requirements
- R1: After reset the event, mask and control words, both alarm values, both timestamps and both low-word shadows read 0, and irq is low.
- R2: Register addresses: 0 event, 1 mask, 2 control, 3/4 alarm 1 high/low, 5/6 alarm 2 high/low, 7/8 trigger 1 stamp high/low, 9/10 trigger 2 stamp high/low. Any other address reads 0.
- R3: Event bit layout: trigger 2 captured = bit 25, trigger 1 captured = bit 24, alarm 2 = bit 17, alarm 1 = bit 16, pulse channels 1, 2, 3 = bits 7, 6, 5. All other event bits read 0.
- R4: A write to the event word clears every bit written as 1 and keeps every bit written as 0. A source that sets a bit in the same cycle wins over the clear.
- R5: The mask word keeps only the bit positions listed in R3, and irq is the OR over all bits of (event AND mask).
- R6: Control bit 8 selects the edge for trigger 1 and bit 9 the edge for trigger 2 (0 = rising, 1 = falling). All other control bits read 0.
- R7: Call E0 the first rising clock edge at which a changed trigger level is present. The matching timestamp takes time_now as sampled at E0. The stamp and its event bit become visible after the second edge following E0.
- R8: A new qualifying edge overwrites the stored timestamp, even while its event bit is still set.
- R9: A read strobe on a stamp's high-word address copies that stamp's low word into a shadow. The low-word address returns this shadow, so a high-then-low read pair stays coherent even if a newer capture arrives between the two reads.
- R10: An alarm fires at a clock edge when it is armed, a previous sample exists, and previous sample < alarm <= time_now. Its event bit is visible after that edge.
- R11: Writing an alarm's high word arms it. Writing its low word disarms it. Firing disarms it, so it fires once per arm, and an alarm armed at a value already passed never fires.
- R12: Each pulse_evt bit (bit 0 = channel 1, bit 1 = channel 2, bit 2 = channel 3) high at a clock edge sets its event bit.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | 64 | Current counter value |
| trig_in | input | 2 | Asynchronous trigger pins (bit 0 = trigger 1) |
| pulse_evt | input | 3 | Single-cycle ticks from the pulse channels |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the shadow latch) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Masked event interrupt |

## Verification
The bench drives a counter that advances by seven per cycle across a 32-bit carry. This shows whether a stamp and an alarm use the full 64-bit value or only its low word. Triggers are driven rising and then falling under both polarity settings, and twice without clearing. This separates edge selection, synchronizer compensation and overwrite. Alarms are set three ways: on a value the counter hits exactly, on one it jumps over, and on one already passed. These separate a crossing test from an equality test and show one-shot behaviour. Clears are written in the same cycle as a pulse tick to expose the set-over-clear priority.

// File: rtl/ts_evt_pkg.sv
package ts_evt_pkg;
   // event bit positions (decoded by software and by the mask)
   localparam int EV_TRIG1  = 24;
   localparam int EV_ALM1   = 16;
   localparam int EV_PULSE1 = 7;   // channels 2,3 sit below it
   localparam int CTRL_POL1 = 8;   // trigger 2 polarity at +1
   // register addresses
   localparam int A_EVT     = 0;
   localparam int A_MASK    = 1;
   localparam int A_CTRL    = 2;
   localparam int A_ALM_HI0 = 3;   // alarm n high at 3+2n, low at 4+2n
   localparam int A_TS_HI0  = 7;   // stamp n high at 7+2n, low at 8+2n
endpackage

// File: rtl/ts_trig_capture.sv
module ts_trig_capture #(
   parameter int TIME_W      = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin,
   input  logic              pol_fall,
   input  logic [TIME_W-1:0] time_now,
   output logic              cap_stb,
   output logic [TIME_W-1:0] stamp
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic [TIME_W-1:0]      tpipe_q [SYNC_STAGES];
   logic                   lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
         for (int i = 0; i < SYNC_STAGES; i++) tpipe_q[i] <= '0;
      end else begin
         sync_q     <= {sync_q[SYNC_STAGES-2:0], pin};
         last_q     <= sync_q[LAST];
         tpipe_q[0] <= time_now;
         for (int i = 1; i < SYNC_STAGES; i++) tpipe_q[i] <= tpipe_q[i-1];
      end
   end

   assign lvl     = sync_q[LAST];
   assign cap_stb = pol_fall ? (!lvl && last_q) : (lvl && !last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stamp <= '0;
      else if (cap_stb) stamp <= tpipe_q[LAST];
   end

   // R7: with a fixed polarity, an edge strobe never repeats on the next cycle
   a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb |=> (!cap_stb || (pol_fall != $past(pol_fall))));
endmodule

// File: rtl/ts_alarm_cmp.sv
module ts_alarm_cmp #(
   parameter int TIME_W = 64,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] time_now,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [DATA_W-1:0] wdata,
   output logic              fire,
   output logic [TIME_W-1:0] alarm_val
);
   logic              armed_q;
   logic              prev_ok_q;
   logic [TIME_W-1:0] prev_q;

   assign fire = armed_q && prev_ok_q && (prev_q < alarm_val) && (alarm_val <= time_now);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_val <= '0;
         armed_q   <= 1'b0;
         prev_q    <= '0;
         prev_ok_q <= 1'b0;
      end else begin
         prev_q    <= time_now;
         prev_ok_q <= 1'b1;
         if (wr_hi) alarm_val[TIME_W-1:DATA_W] <= wdata;
         if (wr_lo) alarm_val[DATA_W-1:0]      <= wdata;
         if (wr_hi)              armed_q <= 1'b1;
         else if (wr_lo || fire) armed_q <= 1'b0;
      end
   end

   // R11: one firing per arm
   a_r11_once_per_arm: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);
   a_r11_fire_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !wr_hi) |=> !armed_q);
endmodule

// File: rtl/tstamp_event_unit.sv
module tstamp_event_unit
   import ts_evt_pkg::*;
#(
   parameter int TIME_W      = 64,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int N_TRIG      = 2,
   parameter int N_ALARM     = 2,
   parameter int N_PULSE     = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TIME_W-1:0]  time_now,
   input  logic [N_TRIG-1:0]  trig_in,
   input  logic [N_PULSE-1:0] pulse_evt,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               irq
);
   if (TIME_W != 2 * DATA_W) begin : g_bad_time
      $error("TIME_W must be twice DATA_W");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("event layout needs a 32-bit data word");
   end
   if (N_TRIG < 1 || N_TRIG > 2 || N_ALARM < 1 || N_ALARM > 2 ||
       N_PULSE < 1 || N_PULSE > 3) begin : g_bad_count
      $error("source counts exceed the event layout");
   end

   function automatic logic [DATA_W-1:0] evt_bits();
      logic [DATA_W-1:0] m = '0;
      for (int t = 0; t < N_TRIG; t++)  m[EV_TRIG1 + t]  = 1'b1;
      for (int a = 0; a < N_ALARM; a++) m[EV_ALM1 + a]   = 1'b1;
      for (int p = 0; p < N_PULSE; p++) m[EV_PULSE1 - p] = 1'b1;
      return m;
   endfunction

   function automatic logic [DATA_W-1:0] ctrl_bits();
      logic [DATA_W-1:0] m = '0;
      for (int t = 0; t < N_TRIG; t++) m[CTRL_POL1 + t] = 1'b1;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] EVT_VALID  = evt_bits();
   localparam logic [DATA_W-1:0] CTRL_VALID = ctrl_bits();

   logic [DATA_W-1:0]  evt_q, mask_q, ctrl_q, evt_set, evt_clr;
   logic [N_TRIG-1:0]  cap_stb;
   logic [TIME_W-1:0]  stamp [N_TRIG];
   logic [DATA_W-1:0]  shadow_q [N_TRIG];
   logic [N_ALARM-1:0] alm_fire;
   logic [TIME_W-1:0]  alm_val [N_ALARM];
   logic               wr_evt;

   assign wr_evt = reg_wr && (reg_addr == ADDR_W'(A_EVT));

   for (genvar t = 0; t < N_TRIG; t++) begin : g_trig
      ts_trig_capture #(.TIME_W(TIME_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin      (trig_in[t]),
         .pol_fall (ctrl_q[CTRL_POL1 + t]),
         .time_now (time_now),
         .cap_stb  (cap_stb[t]),
         .stamp    (stamp[t])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            shadow_q[t] <= '0;
         else if (reg_rd && reg_addr == ADDR_W'(A_TS_HI0 + 2 * t))
            shadow_q[t] <= stamp[t][DATA_W-1:0];
      end
   end

   for (genvar a = 0; a < N_ALARM; a++) begin : g_alarm
      ts_alarm_cmp #(.TIME_W(TIME_W), .DATA_W(DATA_W)) u_alm (
         .clk       (clk),
         .rst_n     (rst_n),
         .time_now  (time_now),
         .wr_hi     (reg_wr && reg_addr == ADDR_W'(A_ALM_HI0 + 2 * a)),
         .wr_lo     (reg_wr && reg_addr == ADDR_W'(A_ALM_HI0 + 2 * a + 1)),
         .wdata     (reg_wdata),
         .fire      (alm_fire[a]),
         .alarm_val (alm_val[a])
      );
   end

   always_comb begin
      evt_set = '0;
      for (int t = 0; t < N_TRIG; t++)  evt_set[EV_TRIG1 + t]  = cap_stb[t];
      for (int a = 0; a < N_ALARM; a++) evt_set[EV_ALM1 + a]   = alm_fire[a];
      for (int p = 0; p < N_PULSE; p++) evt_set[EV_PULSE1 - p] = pulse_evt[p];
   end

   assign evt_clr = wr_evt ? reg_wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q  <= '0;
         mask_q <= '0;
         ctrl_q <= '0;
      end else begin
         evt_q <= (evt_q & ~evt_clr) | evt_set;
         if (reg_wr && reg_addr == ADDR_W'(A_MASK)) mask_q <= reg_wdata & EVT_VALID;
         if (reg_wr && reg_addr == ADDR_W'(A_CTRL)) ctrl_q <= reg_wdata & CTRL_VALID;
      end
   end

   assign irq = |(evt_q & mask_q);

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(A_EVT))  reg_rdata = evt_q;
      if (reg_addr == ADDR_W'(A_MASK)) reg_rdata = mask_q;
      if (reg_addr == ADDR_W'(A_CTRL)) reg_rdata = ctrl_q;
      for (int a = 0; a < N_ALARM; a++) begin
         if (reg_addr == ADDR_W'(A_ALM_HI0 + 2 * a))     reg_rdata = alm_val[a][TIME_W-1:DATA_W];
         if (reg_addr == ADDR_W'(A_ALM_HI0 + 2 * a + 1)) reg_rdata = alm_val[a][DATA_W-1:0];
      end
      for (int t = 0; t < N_TRIG; t++) begin
         if (reg_addr == ADDR_W'(A_TS_HI0 + 2 * t))      reg_rdata = stamp[t][TIME_W-1:DATA_W];
         if (reg_addr == ADDR_W'(A_TS_HI0 + 2 * t + 1))  reg_rdata = shadow_q[t];
      end
   end

   // R4: a source setting a bit beats a clear in the same cycle
   a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_set) |=> ((evt_q & $past(evt_set)) == $past(evt_set)));
   // R4: bits written as 0 keep their value
   a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      wr_evt |=> ((evt_q & $past(evt_q & ~reg_wdata)) == $past(evt_q & ~reg_wdata)));
   // R5: with nothing unmasked the interrupt stays low
   a_r5_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq);
endmodule

// File: tb/sim_tstamp_event_unit.sv
module sim_tstamp_event_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] tnow = 64'h0000_0001_FFFF_FF00;
   logic [1:0]  trig = 2'b00;
   logic [2:0]  pev = 3'b000;
   logic        wr = 1'b0, rd = 1'b0;
   logic [3:0]  addr = 4'd0;
   logic [31:0] wdata = 32'd0;
   logic [31:0] rdata;
   logic        irq;

   int    n_chk = 0, n_fail = 0;
   bit    done = 1'b0;
   string req = "R1";

   always #5 clk = ~clk;

   tstamp_event_unit u0 (
      .clk(clk), .rst_n(rst_n), .time_now(tnow), .trig_in(trig), .pulse_evt(pev),
      .reg_wr(wr), .reg_rd(rd), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata), .irq(irq));

   // ---------------- reference model (behavioural, history based) -----------
   bit [31:0] m_evt, m_mask, m_ctrl;
   bit [63:0] m_alm [2];
   bit        m_arm [2];
   bit [63:0] m_prev;
   bit        m_pv;
   bit [63:0] m_ts [2];
   bit [31:0] m_sh [2];
   bit        ph [2][4];   // pin history, [0] = newest sample
   bit [63:0] th [4];      // time history

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_evt = 0; m_mask = 0; m_ctrl = 0; m_prev = 0; m_pv = 0;
         for (int i = 0; i < 2; i++) begin
            m_alm[i] = 0; m_arm[i] = 0; m_ts[i] = 0; m_sh[i] = 0;
            for (int j = 0; j < 4; j++) ph[i][j] = 0;
         end
         for (int j = 0; j < 4; j++) th[j] = 0;
      end else begin
         bit [31:0] set, clr;
         bit        fire [2];
         set = 0;
         for (int j = 3; j > 0; j--) th[j] = th[j-1];
         th[0] = tnow;
         for (int t = 0; t < 2; t++) begin
            bit hit;
            for (int j = 3; j > 0; j--) ph[t][j] = ph[t][j-1];
            ph[t][0] = trig[t];
            if (rd && addr == 4'(7 + 2*t)) m_sh[t] = m_ts[t][31:0];
            hit = m_ctrl[8+t] ? (ph[t][3] && !ph[t][2]) : (ph[t][2] && !ph[t][3]);
            if (hit) begin
               m_ts[t] = th[2];
               set[24+t] = 1'b1;
            end
         end
         for (int a = 0; a < 2; a++) begin
            fire[a] = m_arm[a] && m_pv && (m_prev < m_alm[a]) && (m_alm[a] <= tnow);
            if (fire[a]) set[16+a] = 1'b1;
         end
         for (int p = 0; p < 3; p++) if (pev[p]) set[7-p] = 1'b1;
         clr = (wr && addr == 0) ? wdata : 32'd0;
         m_evt = (m_evt & ~clr) | set;
         if (wr && addr == 1) m_mask = wdata & 32'h0303_00E0;
         if (wr && addr == 2) m_ctrl = wdata & 32'h0000_0300;
         for (int a = 0; a < 2; a++) begin
            if (wr && addr == 4'(3 + 2*a)) m_alm[a][63:32] = wdata;
            if (wr && addr == 4'(4 + 2*a)) m_alm[a][31:0]  = wdata;
            if (wr && addr == 4'(3 + 2*a))                       m_arm[a] = 1'b1;
            else if ((wr && addr == 4'(4 + 2*a)) || fire[a])     m_arm[a] = 1'b0;
         end
         m_prev = tnow;
         m_pv   = 1'b1;
      end
   end

   function automatic bit [31:0] exp_rdata();
      case (addr)
         4'd0:  return m_evt;
         4'd1:  return m_mask;
         4'd2:  return m_ctrl;
         4'd3:  return m_alm[0][63:32];
         4'd4:  return m_alm[0][31:0];
         4'd5:  return m_alm[1][63:32];
         4'd6:  return m_alm[1][31:0];
         4'd7:  return m_ts[0][63:32];
         4'd8:  return m_sh[0];
         4'd9:  return m_ts[1][63:32];
         4'd10: return m_sh[1];
         default: return 32'd0;
      endcase
   endfunction

   // compare, then advance: one clock per call, sampled at the falling edge
   task automatic cyc();
      bit [31:0] er;
      bit        ei;
      @(posedge clk);
      @(negedge clk);
      er = exp_rdata();
      ei = |(m_evt & m_mask);
      n_chk++;
      if (rdata !== er || irq !== ei) begin
         n_fail++;
         $display("FAIL %s addr=%0d actual rdata=%h irq=%b expected rdata=%h irq=%b",
                  req, addr, rdata, irq, er, ei);
      end
      tnow  = tnow + 64'd7;
      wr    = 1'b0;
      rd    = 1'b0;
      pev   = 3'b000;
   endtask

   task automatic cycn(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic wreg(input logic [3:0] a, input logic [31:0] d);
      wr = 1'b1; addr = a; wdata = d;
      cyc();
   endtask

   task automatic view(input logic [3:0] a, input bit strobe);
      addr = a; rd = strobe;
      cyc();
   endtask

   task automatic arm_alarm(input int idx, input logic [63:0] v);
      wreg(4'(4 + 2*idx), v[31:0]);
      wreg(4'(3 + 2*idx), v[63:32]);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements) actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      logic [63:0] tgt;
      // R1: reset values on every address, during and after reset
      req = "R1";
      for (int a = 0; a < 12; a++) view(4'(a), 1'b0);
      rst_n = 1'b1;
      req = "R2";
      for (int a = 0; a < 16; a++) view(4'(a), 1'b0);

      // R12 / R3: pulse channels land on bits 7,6,5
      req = "R12"; addr = 0;
      pev = 3'b001; cyc();
      pev = 3'b110; cyc();
      req = "R3"; cyc();

      // R4: write-1-to-clear, zero keeps, set beats clear
      req = "R4";
      wreg(4'd0, 32'h0000_0000);
      wreg(4'd0, 32'h0000_0040);
      addr = 0; pev = 3'b001; wr = 1'b1; wdata = 32'h0000_00A0; cyc();
      view(4'd0, 1'b0);
      wreg(4'd0, 32'hFFFF_FFFF);

      // R5: mask layout and interrupt
      req = "R5";
      wreg(4'd1, 32'hFFFF_FFFF);
      view(4'd1, 1'b0);
      pev = 3'b001; cyc();
      wreg(4'd1, 32'h0000_0040);
      view(4'd0, 1'b0);
      pev = 3'b010; cyc(); cyc();
      wreg(4'd0, 32'hFFFF_FFFF);
      wreg(4'd1, 32'h0303_0000);

      // R7: rising capture on trigger 1, across the 32-bit carry
      req = "R7"; addr = 0;
      trig[0] = 1'b1; cycn(4);
      view(4'd7, 1'b1); view(4'd8, 1'b0);
      // R6: falling selected for trigger 1; a rising edge is ignored
      req = "R6";
      wreg(4'd2, 32'hFFFF_FFFF);
      view(4'd2, 1'b0);
      wreg(4'd0, 32'hFFFF_FFFF);
      trig[0] = 1'b0; cycn(4);
      trig[0] = 1'b1; cycn(4);
      view(4'd7, 1'b1); view(4'd8, 1'b0);
      // R6: trigger 2 falling, then rising after switching polarity back
      trig[1] = 1'b1; cycn(4);
      trig[1] = 1'b0; cycn(4);
      view(4'd9, 1'b1); view(4'd10, 1'b0);
      wreg(4'd2, 32'h0000_0000);
      trig[1] = 1'b1; addr = 0; cycn(4);
      view(4'd9, 1'b1); view(4'd10, 1'b0);

      // R8: two captures without clearing, the later one stays
      req = "R8";
      wreg(4'd0, 32'hFFFF_FFFF);
      trig[0] = 1'b0; cycn(3);
      trig[0] = 1'b1; cycn(3);
      trig[0] = 1'b0; cycn(3);
      trig[0] = 1'b1; addr = 0; cycn(4);
      view(4'd7, 1'b1); view(4'd8, 1'b0);

      // R9: high read, newer capture, low read returns the earlier sample
      req = "R9";
      view(4'd7, 1'b1);
      trig[0] = 1'b0; cycn(3);
      trig[0] = 1'b1; cycn(4);
      view(4'd8, 1'b0);
      view(4'd7, 1'b1); view(4'd8, 1'b0);

      // R10: exact hit on alarm 1 and a jumped-over value on alarm 2
      req = "R10";
      wreg(4'd0, 32'hFFFF_FFFF);
      wreg(4'd1, 32'h0003_0000);
      tgt = tnow + 64'd14 + 64'd70;
      arm_alarm(0, tgt);
      tgt = tnow + 64'd14 + 64'd53;
      arm_alarm(1, tgt);
      addr = 0; cycn(16);
      // R11: periodic re-arm, past value, and disarm by low write
      req = "R11";
      wreg(4'd0, 32'hFFFF_FFFF);
      tgt = tnow + 64'd14 + 64'd100;
      arm_alarm(0, tgt);
      addr = 0; cycn(20);
      view(4'd3, 1'b0); view(4'd4, 1'b0);
      wreg(4'd0, 32'hFFFF_FFFF);
      tgt = tnow - 64'd200;
      arm_alarm(1, tgt);
      addr = 0; cycn(10);
      tgt = tnow + 64'd30;
      wreg(4'd5, tgt[63:32]);
      wreg(4'd6, tgt[31:0]);
      addr = 0; cycn(10);
      view(4'd5, 1'b0); view(4'd6, 1'b0);

      finish_run();
   end
endmodule